// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame passes the receive address filter. A request gives the 48-bit destination address together with a six-bit acceptance mode and two frame-quality flags (runt, error). A serial engine runs a CRC-32 over the address one bit per cycle. The upper six bits of the final CRC form a hash index into a 64-bit multicast filter, which is kept as two 32-bit words behind a small register port.

The block also detects the broadcast address and an exact match against the station address. It reports one accept decision along with flags that say how the address matched. The results are held on the outputs until the next decision replaces them. A `done` strobe marks each new decision.

Top module: `mhf_filter`

## Requirements
- R1: The CRC register starts at 0xFFFFFFFF. Address bits are consumed in order `req_addr[0]` to `req_addr[47]`, so byte 0 sits in bits 7:0 and each byte goes least significant bit first. For each bit, c = crc[31] XOR bit, then crc is shifted left by one. If c is 1, crc becomes (crc XOR 0x04C11DB6) OR 1. `hash_idx` reports crc[31:26].
- R2: A hash index below 32 selects that bit of filter word 0. An index of 32 or more selects bit (index − 32) of filter word 1.
- R3: Both filter words reset to zero, so after reset a multicast address is rejected.
- R4: A filter word is written with `reg_wr_en`, using `reg_wr_sel` (0 for word 0, 1 for word 1). `reg_rd_data` shows the word chosen by `reg_rd_sel` without delay and reflects a write from the next cycle on.
- R5: A request accepted at a clock edge produces a one-cycle `done` pulse 49 clock edges later. `accept`, the three hit flags and `hash_idx` change only together with `done` and otherwise hold their values.
- R6: A request presented while an earlier one is still being computed is ignored. It produces no extra decision and does not alter the pending result.
- R7: An all-ones address sets `hit_bcast`, never sets `hit_mcast`, and is accepted only when mode bit 3 is set.
- R8: An address equal to `station_addr` sets `hit_phys` and is accepted when mode bit 1 is set. A unicast address that differs from it is rejected under that mode.
- R9: Mode bit 0 accepts any address.
- R10: A frame flagged runt is accepted only if mode bit 4 is set. A frame flagged error is accepted only if mode bit 5 is set. This applies whatever the address match.
- R11: `hit_mcast` is set for a non-broadcast address with bit 0 set whose hash bit is 1. Such a frame is accepted under mode bit 2 and rejected when that bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a decision for the fields below |
| req_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| req_mode | input | 6 | Acceptance mode bits (0 any, 1 station, 2 multicast, 3 broadcast, 4 runt, 5 error) |
| req_runt | input | 1 | Frame is a runt |
| req_err | input | 1 | Frame carries a receive error |
| station_addr | input | 48 | Own station address, same byte layout as `req_addr` |
| reg_wr_en | input | 1 | Filter word write strobe |
| reg_wr_sel | input | 1 | Filter word selected for writing |
| reg_wr_data | input | 32 | Filter word write data |
| reg_rd_sel | input | 1 | Filter word selected for reading |
| reg_rd_data | output | 32 | Selected filter word |
| done | output | 1 | One-cycle strobe: new decision on the outputs |
| accept | output | 1 | Frame passes the filter |
| hit_bcast | output | 1 | Address is broadcast |
| hit_mcast | output | 1 | Group address whose hash bit is set |
| hit_phys | output | 1 | Address equals the station address |
| hash_idx | output | 6 | Hash index of the last decision |

## Verification
Each decision appears on the outputs exactly 49 clock edges after the edge that captured its request. The bench counts falling edges from that capture and requires `done` to be seen on the 49th one. It checks results only in that window, and verifies they still hold several cycles later. Filter reads are combinational, so they are sampled one time step after `reg_rd_sel` settles, and only on the falling edge after a write. The ignored-request case places a second request ten cycles into a pending one. It then confirms the single `done` arrives on schedule with the first request's result, and that no further `done` follows.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int MODE_W     = 6;
  localparam int MODE_ANY   = 0;
  localparam int MODE_PHYS  = 1;
  localparam int MODE_MCAST = 2;
  localparam int MODE_BCAST = 3;
  localparam int MODE_RUNT  = 4;
  localparam int MODE_ERR   = 5;

  typedef struct packed {
    logic accept;
    logic bcast;
    logic mcast;
    logic phys;
  } mhf_verdict_t;
endpackage

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine #(
  parameter int ADDR_W = 48,
  parameter int CRC_W  = 32,
  parameter int IDX_W  = 6,
  parameter logic [CRC_W-1:0] POLY   = 32'h04C11DB6,
  parameter logic [CRC_W-1:0] PRESET = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              fin,
  output logic [IDX_W-1:0]  idx
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ADDR_W - 1);

  logic [CRC_W-1:0]  crc_q, crc_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d, fin_q, fin_d;
  logic              carry;

  always_comb begin
    crc_d  = crc_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    carry  = 1'b0;
    if (start && !busy_q) begin
      crc_d  = PRESET;
      sh_d   = addr;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      carry = crc_q[CRC_W-1] ^ sh_q[0];
      crc_d = {crc_q[CRC_W-2:0], 1'b0};
      if (carry) crc_d = (crc_d ^ POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      fin_q  <= fin_d;
    end
  end

  assign busy = busy_q;
  assign fin  = fin_q;
  assign idx  = crc_q[CRC_W-1 -: IDX_W];
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
  parameter int IDX_W = 6,
  parameter int REG_W = 32,
  localparam int NREG  = (1 << IDX_W) / REG_W,
  localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic [IDX_W-1:0] idx,
  output logic             hit
);
  logic [NREG-1:0][REG_W-1:0] bank_q, bank_d;
  logic [NREG-1:0]            we;
  logic [NREG*REG_W-1:0]      flat;

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign we[g] = wr_en && (wr_sel == SEL_W'(g));
  end

  always_comb begin
    bank_d = bank_q;
    for (int k = 0; k < NREG; k++) begin
      if (we[k]) bank_d[k] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign rd_data = bank_q[rd_sel];
  assign flat    = bank_q;
  assign hit     = flat[idx];
endmodule

// File: rtl/mhf_classify.sv
module mhf_classify
  import mhf_pkg::*;
#(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] station,
  input  logic [MODE_W-1:0] mode,
  input  logic              runt,
  input  logic              err,
  input  logic              hash_hit,
  output mhf_verdict_t      verdict
);
  logic bcast, group, gate, pass;

  always_comb begin
    bcast = &addr;
    group = addr[0] && !bcast;
    verdict.bcast = bcast;
    verdict.mcast = group && hash_hit;
    verdict.phys  = (addr == station);
    gate = (!runt || mode[MODE_RUNT]) && (!err || mode[MODE_ERR]);
    pass = mode[MODE_ANY]
         || (verdict.phys  && mode[MODE_PHYS])
         || (verdict.mcast && mode[MODE_MCAST])
         || (verdict.bcast && mode[MODE_BCAST]);
    verdict.accept = gate && pass;
  end
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CRC_W  = 32,
  parameter int IDX_W  = 6,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_runt,
  input  logic              req_err,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              reg_rd_sel,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              done,
  output logic              accept,
  output logic              hit_bcast,
  output logic              hit_mcast,
  output logic              hit_phys,
  output logic [IDX_W-1:0]  hash_idx
);
  logic              busy, fin, hash_hit, take;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q, addr_d, stn_q, stn_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              runt_q, runt_d, err_q, err_d;
  mhf_verdict_t      verdict, res_q, res_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              done_q;

  assign take = req_valid && !busy;

  mhf_crc_engine #(.ADDR_W(ADDR_W), .CRC_W(CRC_W), .IDX_W(IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(req_valid), .addr(req_addr),
    .busy(busy), .fin(fin), .idx(idx)
  );

  mhf_hash_table #(.IDX_W(IDX_W), .REG_W(REG_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
    .idx(idx), .hit(hash_hit)
  );

  mhf_classify #(.ADDR_W(ADDR_W)) u_cls (
    .addr(addr_q), .station(stn_q), .mode(mode_q), .runt(runt_q),
    .err(err_q), .hash_hit(hash_hit), .verdict(verdict)
  );

  always_comb begin
    addr_d = take ? req_addr     : addr_q;
    stn_d  = take ? station_addr : stn_q;
    mode_d = take ? req_mode     : mode_q;
    runt_d = take ? req_runt     : runt_q;
    err_d  = take ? req_err      : err_q;
    res_d  = fin  ? verdict      : res_q;
    idx_d  = fin  ? idx          : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      stn_q  <= '0;
      mode_q <= '0;
      runt_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      stn_q  <= stn_d;
      mode_q <= mode_d;
      runt_q <= runt_d;
      err_q  <= err_d;
      res_q  <= res_d;
      idx_q  <= idx_d;
      done_q <= fin;
    end
  end

  assign done      = done_q;
  assign accept    = res_q.accept;
  assign hit_bcast = res_q.bcast;
  assign hit_mcast = res_q.mcast;
  assign hit_phys  = res_q.phys;
  assign hash_idx  = idx_q;
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk #(
  parameter int IDX_W = 6,
  parameter int REG_W = 32,
  parameter int GAP   = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             accept,
  input logic             hit_bcast,
  input logic             hit_mcast,
  input logic [IDX_W-1:0] hash_idx,
  input logic             reg_wr_en,
  input logic             reg_wr_sel,
  input logic [REG_W-1:0] reg_wr_data,
  input logic             reg_rd_sel,
  input logic [REG_W-1:0] reg_rd_data
);
  localparam int GW = $clog2(GAP + 1);
  logic [GW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_q <= GW'(GAP);
    else if (done)               since_q <= '0;
    else if (since_q != GW'(GAP)) since_q <= since_q + 1'b1;
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(accept) && $stable(hash_idx)));

  p_bcast_not_mcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bcast |-> !hit_mcast);

  p_wr_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (reg_rd_sel == reg_wr_sel)) |=> (reg_rd_data == $past(reg_wr_data)));

  p_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_q == GW'(GAP)));
endmodule

bind mhf_filter mhf_filter_chk #(.IDX_W(IDX_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .accept(accept),
  .hit_bcast(hit_bcast), .hit_mcast(hit_mcast), .hash_idx(hash_idx),
  .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
  .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data)
);

// File: tb/mhf_filter_test.sv
module mhf_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [47:0] req_addr = '0;
  logic [5:0]  req_mode = '0;
  logic        req_runt = 1'b0, req_err = 1'b0;
  logic [47:0] station_addr = 48'h6655_4433_2210;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0, reg_rd_sel = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        done, accept, hit_bcast, hit_mcast, hit_phys;
  logic [5:0]  hash_idx;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  mhf_filter uut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    logic        cy;
    c = 32'hFFFF_FFFF;
    for (int n = 0; n < 48; n++) begin
      cy = c[31] ^ a[n];
      c  = {c[30:0], 1'b0};
      if (cy) c = (c ^ 32'h04C1_1DB6) | 32'h1;
    end
    return c[31:26];
  endfunction

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_rd_sel = sel;
    #1 d = reg_rd_data;
  endtask

  task automatic run(input logic [47:0] a, input logic [5:0] m,
                     input bit runt, input bit err, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_mode = m; req_runt = runt; req_err = err;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [47:0] a;
    logic [5:0]  ei;
    int          lat, cnt;
    logic [31:0] lo, hi;

    repeat (3) @(negedge clk);
    chk(done == 0 && accept == 0, "R3 reset outputs", {done, accept}, 0);
    rd(0, d); chk(d == 0, "R3 word0 reset", d, 0);
    rd(1, d); chk(d == 0, "R3 word1 reset", d, 0);
    rst_n = 1'b1;

    // R3: empty filter rejects multicast
    run(48'h0000_5E00_0001, 6'b000100, 0, 0, lat);
    chk(lat == 49, "R5 latency", lat, 49);
    chk(accept == 0 && hit_mcast == 0, "R3 empty filter reject", accept, 0);

    // R4: register port
    wr(0, 32'hA5A5_0F0F); wr(1, 32'h1234_5678);
    rd(0, d); chk(d == 32'hA5A5_0F0F, "R4 word0 readback", d, 32'hA5A5_0F0F);
    rd(1, d); chk(d == 32'h1234_5678, "R4 word1 readback", d, 32'h1234_5678);

    // R1, R2, R11 sweep over multicast addresses
    for (int i = 0; i < 40; i++) begin
      a  = {32'(i) * 32'h9E37_79B1, (16'h5E00 ^ 16'(i << 4)) | 16'h0001};
      ei = ref_idx(a);
      lo = (ei < 32) ? (32'h1 << ei) : 32'h0;
      hi = (ei >= 32) ? (32'h1 << (ei - 32)) : 32'h0;
      wr(0, lo); wr(1, hi);
      run(a, 6'b000100, 0, 0, lat);
      chk(lat == 49, "R5 latency sweep", lat, 49);
      chk(hash_idx == ei, "R1 hash index", hash_idx, ei);
      chk(accept == 1 && hit_mcast == 1, "R2 selected bit accepts", {accept, hit_mcast}, 3);
      wr(0, ~lo); wr(1, ~hi);
      run(a, 6'b000100, 0, 0, lat);
      chk(accept == 0 && hit_mcast == 0, "R11 other bits reject", {accept, hit_mcast}, 0);
      if (i < 4) begin
        wr(0, lo); wr(1, hi);
        run(a, 6'b000000, 0, 0, lat);
        chk(accept == 0 && hit_mcast == 1, "R11 mode bit2 clear rejects", {accept, hit_mcast}, 1);
      end
    end

    // R5 hold after decision
    run(48'hFFFF_FFFF_FFFF, 6'b001000, 0, 0, lat);
    repeat (5) @(negedge clk);
    chk(done == 0 && accept == 1 && hit_bcast == 1, "R5 outputs held", {done, accept, hit_bcast}, 3);

    // R7 broadcast
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    run(48'hFFFF_FFFF_FFFF, 6'b000100, 0, 0, lat);
    chk(accept == 0 && hit_bcast == 1 && hit_mcast == 0, "R7 bcast not multicast",
        {accept, hit_bcast, hit_mcast}, 3'b010);
    run(48'hFFFF_FFFF_FFFF, 6'b001000, 0, 0, lat);
    chk(accept == 1, "R7 bcast accepted", accept, 1);

    // R8 station match
    run(station_addr, 6'b000010, 0, 0, lat);
    chk(accept == 1 && hit_phys == 1, "R8 station accepted", {accept, hit_phys}, 3);
    run(station_addr ^ 48'h0100_0000_0000, 6'b000010, 0, 0, lat);
    chk(accept == 0 && hit_phys == 0, "R8 other unicast rejected", {accept, hit_phys}, 0);

    // R9 accept all
    run(48'h0123_4567_89AA, 6'b000001, 0, 0, lat);
    chk(accept == 1, "R9 any address", accept, 1);

    // R10 runt and error gating
    run(48'hFFFF_FFFF_FFFF, 6'b001000, 1, 0, lat);
    chk(accept == 0, "R10 runt rejected", accept, 0);
    run(48'hFFFF_FFFF_FFFF, 6'b011000, 1, 0, lat);
    chk(accept == 1, "R10 runt allowed", accept, 1);
    run(48'hFFFF_FFFF_FFFF, 6'b001000, 0, 1, lat);
    chk(accept == 0, "R10 error rejected", accept, 0);
    run(48'hFFFF_FFFF_FFFF, 6'b101001, 0, 1, lat);
    chk(accept == 1, "R10 error allowed", accept, 1);
    run(48'h0123_4567_89AA, 6'b000001, 1, 1, lat);
    chk(accept == 0, "R10 gate overrides any", accept, 0);

    // R6 request while busy ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 48'hFFFF_FFFF_FFFF; req_mode = 6'b001000;
    req_runt = 0; req_err = 0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      if (lat == 10) begin
        req_valid = 1'b1; req_addr = 48'h0123_4567_89AA; req_mode = 6'b000000;
      end else req_valid = 1'b0;
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk(lat == 49, "R6 first result on time", lat, 49);
    chk(accept == 1 && hit_bcast == 1, "R6 pending result kept", {accept, hit_bcast}, 3);
    cnt = 0;
    repeat (80) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk(cnt == 0, "R6 no extra decision", cnt, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule